// File: doc/BRIEF.md
# H-Bridge Gate Control with Current Chopping

This block is the digital controller for one H-bridge. Two command inputs choose one of four bridge states: both legs floating, one leg pulled up while the other is pulled down (in either direction), or both legs pulled down. From the chosen state it produces the four gate enables, one high-side and one low-side for each leg. Before the commands are used they are filtered, so a short glitch has no effect. Each leg switches break-before-make, so it never turns one of its switches on until the other has been off for a programmable dead time.

A fixed-period chopper sits between the decoded state and the legs. It limits winding current using a synchronized flag from an external sense comparator. The period counter runs from the block's own clock, and the command inputs do not affect it. When the bridge is driving, the comparator flag is ignored for a blanking window after conduction starts. If the flag is seen after that window, the bridge is put into slow decay with both low-side switches on. It stays there until the next period boundary and then drives again. An external disable input turns every gate off at once and restarts the chopping period.

All times are parameters given in clock cycles: the filter length, the dead time, the blanking window and the chopping period.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: Command pair {ctl_a_i, ctl_b_i} = 00 (coast) turns off all four gate enables once it has passed the input filter.
- R2: Command 10 (forward) gives leg1 high-side on and leg2 low-side on. Command 01 (reverse) gives leg1 low-side on and leg2 high-side on. The other two gates stay off in both cases.
- R3: Command 11 (brake) turns on both low-side gates and leaves both high-side gates off.
- R4: A change on a command input takes effect only after it has been stable for DEGLITCH_CYC consecutive clock edges. The gates respond one edge later than that. A pulse shorter than DEGLITCH_CYC cycles leaves the gates unchanged.
- R5: A leg never has its high-side and low-side gates on together. Before one gate of a leg turns on after the other gate, both gates are off for at least DEAD_CYC cycles.
- R6: During the first BLANK_CYC cycles of conduction in forward or reverse, the sense flag is ignored. This includes the conduction that restarts at each period boundary.
- R7: If the sense flag is seen after blanking while the bridge drives forward or reverse, both high-side gates turn off and both low-side gates turn on. The bridge holds this state until the next period boundary and then drives the commanded direction again.
- R8: Period boundaries fall every PERIOD_CYC cycles. They are counted from reset release or from the release of bridge_off_i, and the command inputs do not move them.
- R9: In coast and in brake, the sense flag has no effect on the gates.
- R10: While bridge_off_i is high, all four gate enables are low in the same cycle, and the chopping period restarts when it is released.
- R11: With the sense flag held low, the gates settle to the decoded command for every command pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_a_i | input | 1 | Command bit A (first of the pair) |
| ctl_b_i | input | 1 | Command bit B (second of the pair) |
| sense_trip_i | input | 1 | Asynchronous current-sense comparator flag, high when over threshold |
| bridge_off_i | input | 1 | Forces all gates off and restarts the chopping period |
| leg1_hi_o | output | 1 | Leg 1 high-side gate enable |
| leg1_lo_o | output | 1 | Leg 1 low-side gate enable |
| leg2_hi_o | output | 1 | Leg 2 high-side gate enable |
| leg2_lo_o | output | 1 | Leg 2 low-side gate enable |

## Verification
The bench pulses a command for one cycle less than the filter length, which a filter with an off-by-one error would pass to the gates. It then checks the exact edge on which a held command first reaches them. With the sense flag held high, it releases the disable so the period phase is known, and checks three things: drive during blanking, which a design that ignores blanking would brake; slow decay just before the boundary, which a design that clears the trip early would lose; and drive again just after two successive boundaries, which a design with a wrong period length or no re-apply would miss. It also toggles the sense flag at random in coast and brake, applies random commands with and without sense, and watches every leg for overlap or a short off gap, which would show up as shoot-through or a missing dead time.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Drive state encoding is the command pair {a, b}.
  typedef enum logic [1:0] {
    DRV_COAST = 2'b00,
    DRV_REV   = 2'b01,
    DRV_FWD   = 2'b10,
    DRV_BRAKE = 2'b11
  } drive_e;

  // Leg request: bit 1 = high-side, bit 0 = low-side.
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_e;

  function automatic logic is_conducting(drive_e d);
    return (d == DRV_FWD) || (d == DRV_REV);
  endfunction

  // Maps a bridge state to the request of leg 1 (second = 0) or leg 2.
  function automatic leg_e leg_request(drive_e d, logic second);
    case (d)
      DRV_FWD:   return second ? LEG_LO : LEG_HI;
      DRV_REV:   return second ? LEG_HI : LEG_LO;
      DRV_BRAKE: return LEG_LO;
      default:   return LEG_OFF;
    endcase
  endfunction

endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
  parameter int unsigned DEGLITCH_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(DEGLITCH_CYC + 1);

  logic [CW-1:0] stable_cnt;
  logic          differs;
  logic          accept;

  assign differs = (din != dout);
  assign accept  = differs && (stable_cnt == CW'(DEGLITCH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= 1'b0;
      stable_cnt <= '0;
    end else if (accept) begin
      dout       <= din;
      stable_cnt <= '0;
    end else if (differs) begin
      stable_cnt <= stable_cnt + 1'b1;
    end else begin
      stable_cnt <= '0;
    end
  end
endmodule

// File: rtl/hb_sync2.sv
module hb_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      meta   <= async_i;
      sync_o <= meta;
    end
  end
endmodule

// File: rtl/hb_chopper.sv
module hb_chopper
  import hb_pkg::*;
#(
  parameter int unsigned BLANK_CYC  = 188,
  parameter int unsigned PERIOD_CYC = 1000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   off_i,
  input  drive_e mode_i,
  input  logic   sense_i,
  output drive_e target_o,
  output logic   chop_o,
  output logic   blank_done_o
);
  localparam int unsigned PW = $clog2(PERIOD_CYC);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);

  logic [PW-1:0] period_cnt;
  logic [BW-1:0] blank_cnt;
  drive_e        mode_q;
  logic          period_start;
  logic          driving;

  assign driving      = is_conducting(mode_i);
  assign period_start = (period_cnt == PW'(PERIOD_CYC - 1));
  assign blank_done_o = (blank_cnt == BW'(BLANK_CYC));
  assign target_o     = (driving && chop_o) ? DRV_BRAKE : mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_cnt <= '0;
      blank_cnt  <= '0;
      chop_o     <= 1'b0;
      mode_q     <= DRV_COAST;
    end else if (off_i) begin
      period_cnt <= '0;
      blank_cnt  <= '0;
      chop_o     <= 1'b0;
      mode_q     <= mode_i;
    end else begin
      mode_q     <= mode_i;
      period_cnt <= period_start ? '0 : period_cnt + 1'b1;

      if (!driving || period_start)
        chop_o <= 1'b0;
      else if (blank_done_o && sense_i)
        chop_o <= 1'b1;

      // Blanking restarts whenever conduction (re)starts or changes direction.
      if (!driving || chop_o || (mode_i != mode_q))
        blank_cnt <= '0;
      else if (!blank_done_o)
        blank_cnt <= blank_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_i,
  input  leg_e want_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);

  leg_e          applied;
  logic [DW-1:0] off_cnt;
  logic          gap_met;

  assign gap_met = (off_cnt == DW'(DEAD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied <= LEG_OFF;
      off_cnt <= DW'(DEAD_CYC);
    end else if (off_i || (applied != LEG_OFF && want_i != applied)) begin
      if (applied != LEG_OFF) off_cnt <= '0;
      else if (!gap_met)      off_cnt <= off_cnt + 1'b1;
      applied <= LEG_OFF;
    end else if (applied == LEG_OFF) begin
      if (want_i != LEG_OFF && gap_met)
        applied <= want_i;
      else if (!gap_met)
        off_cnt <= off_cnt + 1'b1;
    end
  end

  assign hi_o = applied[1] & ~off_i;
  assign lo_o = applied[0] & ~off_i;
endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = 22,
  parameter int unsigned DEAD_CYC     = 22,
  parameter int unsigned BLANK_CYC    = 188,
  parameter int unsigned PERIOD_CYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_a_i,
  input  logic ctl_b_i,
  input  logic sense_trip_i,
  input  logic bridge_off_i,
  output logic leg1_hi_o,
  output logic leg1_lo_o,
  output logic leg2_hi_o,
  output logic leg2_lo_o
);
  localparam int unsigned NLEG = 2;

  logic [1:0]      raw_cmd;
  logic [1:0]      clean_cmd;
  drive_e          drive_mode;
  drive_e          target_mode;
  logic            sense_s;
  logic            chop_active;
  logic            blank_done;
  leg_e            leg_want [NLEG];
  logic [NLEG-1:0] gate_hi;
  logic [NLEG-1:0] gate_lo;

  assign raw_cmd = {ctl_a_i, ctl_b_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    hb_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_cmd[g]),
      .dout (clean_cmd[g])
    );
  end

  assign drive_mode = drive_e'(clean_cmd);

  hb_sync2 u_sense_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(sense_trip_i),
    .sync_o (sense_s)
  );

  hb_chopper #(.BLANK_CYC(BLANK_CYC), .PERIOD_CYC(PERIOD_CYC)) u_chop (
    .clk         (clk),
    .rst_n       (rst_n),
    .off_i       (bridge_off_i),
    .mode_i      (drive_mode),
    .sense_i     (sense_s),
    .target_o    (target_mode),
    .chop_o      (chop_active),
    .blank_done_o(blank_done)
  );

  for (genvar l = 0; l < NLEG; l++) begin : g_leg
    assign leg_want[l] = leg_request(target_mode, l[0]);
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .off_i (bridge_off_i),
      .want_i(leg_want[l]),
      .hi_o  (gate_hi[l]),
      .lo_o  (gate_lo[l])
    );
  end

  assign leg1_hi_o = gate_hi[0];
  assign leg1_lo_o = gate_lo[0];
  assign leg2_hi_o = gate_hi[1];
  assign leg2_lo_o = gate_lo[1];
endmodule

// File: rtl/hbridge_chop_ctrl_chk.sv
module hbridge_chop_ctrl_chk #(
  parameter int unsigned DEAD_CYC = 22
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bridge_off_i,
  input logic [1:0] drive_mode,
  input logic       chop_active,
  input logic       blank_done,
  input logic       leg1_hi_o,
  input logic       leg1_lo_o,
  input logic       leg2_hi_o,
  input logic       leg2_lo_o
);
  localparam int unsigned RW = $clog2(DEAD_CYC + 1);

  logic [3:0]    gates;
  logic [RW-1:0] off_run [4];

  assign gates = {leg1_hi_o, leg1_lo_o, leg2_hi_o, leg2_lo_o};

  // Consecutive sampled off cycles per gate, saturating at the dead time.
  for (genvar i = 0; i < 4; i++) begin : g_run
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         off_run[i] <= RW'(DEAD_CYC);
      else if (gates[i])                  off_run[i] <= '0;
      else if (off_run[i] != RW'(DEAD_CYC)) off_run[i] <= off_run[i] + 1'b1;
    end
  end

  assert_coast_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_mode == hb_pkg::DRV_COAST) |=> (gates == 4'b0000));

  assert_brake_no_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_mode == hb_pkg::DRV_BRAKE) |=> (!leg1_hi_o && !leg2_hi_o));

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg1_hi_o && leg1_lo_o) && !(leg2_hi_o && leg2_lo_o));

  assert_gap_leg1_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg1_hi_o) |-> (off_run[2] >= RW'(DEAD_CYC)));
  assert_gap_leg1_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg1_lo_o) |-> (off_run[3] >= RW'(DEAD_CYC)));
  assert_gap_leg2_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg2_hi_o) |-> (off_run[0] >= RW'(DEAD_CYC)));
  assert_gap_leg2_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(leg2_lo_o) |-> (off_run[1] >= RW'(DEAD_CYC)));

  assert_trip_after_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chop_active) |-> $past(blank_done));

  assert_chop_high_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chop_active |=> (!leg1_hi_o && !leg2_hi_o));

  assert_idle_no_chop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_mode == hb_pkg::DRV_COAST) || (drive_mode == hb_pkg::DRV_BRAKE))
      |=> !chop_active);

  assert_disable_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_off_i |-> (gates == 4'b0000));

  assert_disable_clears_chop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_off_i |=> !chop_active);
endmodule

bind hbridge_chop_ctrl hbridge_chop_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bridge_off_i(bridge_off_i),
  .drive_mode  (drive_mode),
  .chop_active (chop_active),
  .blank_done  (blank_done),
  .leg1_hi_o   (leg1_hi_o),
  .leg1_lo_o   (leg1_lo_o),
  .leg2_hi_o   (leg2_hi_o),
  .leg2_lo_o   (leg2_lo_o)
);

// File: tb/hbridge_chop_ctrl_test.sv
module hbridge_chop_ctrl_test;
  localparam int DG  = 4;
  localparam int DT  = 3;
  localparam int BL  = 12;
  localparam int PER = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_a = 1'b0, ctl_b = 1'b0, sense = 1'b0, boff = 1'b0;
  logic l1h, l1l, l2h, l2l;

  int checks = 0;
  int errors = 0;
  int shoot_viol = 0;
  int gap_viol = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hbridge_chop_ctrl #(
    .DEGLITCH_CYC(DG), .DEAD_CYC(DT), .BLANK_CYC(BL), .PERIOD_CYC(PER)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ctl_a_i(ctl_a), .ctl_b_i(ctl_b),
    .sense_trip_i(sense), .bridge_off_i(boff),
    .leg1_hi_o(l1h), .leg1_lo_o(l1l), .leg2_hi_o(l2h), .leg2_lo_o(l2l)
  );

  // Expected gates {l1h,l1l,l2h,l2l} for a settled command pair {a,b}.
  function automatic logic [3:0] gates_for(logic [1:0] ab);
    case (ab)
      2'b00:   return 4'b0000;
      2'b10:   return 4'b1001;
      2'b01:   return 4'b0110;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic logic [3:0] now_gates();
    return {l1h, l1l, l2h, l2l};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(logic [1:0] ab);
    ctl_a = ab[1];
    ctl_b = ab[0];
  endtask

  // Independent monitor of overlap and the off gap on each leg.
  int    gap1 = 100, gap2 = 100;
  logic  last1 = 1'b0, last2 = 1'b0;  // last side on: 1 = high, 0 = low
  bit    seen1 = 1'b0, seen2 = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if ((l1h && l1l) || (l2h && l2l)) shoot_viol++;
    if (l1h || l1l) begin
      if (seen1 && (l1h != last1) && gap1 < DT) gap_viol++;
      last1 = l1h; seen1 = 1'b1; gap1 = 0;
    end else gap1++;
    if (l2h || l2l) begin
      if (seen2 && (l2h != last2) && gap2 < DT) gap_viol++;
      last2 = l2h; seen2 = 1'b1; gap2 = 0;
    end else gap2++;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] obs;
    bit         held;
    void'($urandom(32'h1D5E_ED01));

    cyc(3);
    check("R1 reset", now_gates(), 4'b0000);
    rst_n = 1'b1;
    cyc(5);
    check("R1 coast after reset", now_gates(), 4'b0000);

    // R4: short pulse ignored, held command acts on exact edge.
    set_cmd(2'b10);
    cyc(DG - 1);
    set_cmd(2'b00);
    held = 1'b1;
    for (int i = 0; i < 15; i++) begin
      cyc(1);
      if (now_gates() != 4'b0000) held = 1'b0;
    end
    check("R4 short pulse ignored", held ? 4'b0000 : 4'b1111, 4'b0000);
    set_cmd(2'b10);
    cyc(DG);
    check("R4 not yet applied", now_gates(), 4'b0000);
    cyc(1);
    check("R4 applied next edge R2", now_gates(), 4'b1001);

    // R2 reverse, R3 brake, R1 coast directed.
    set_cmd(2'b01); cyc(30);
    check("R2 reverse", now_gates(), gates_for(2'b01));
    set_cmd(2'b11); cyc(30);
    check("R3 brake", now_gates(), gates_for(2'b11));
    set_cmd(2'b00); cyc(30);
    check("R1 coast", now_gates(), gates_for(2'b00));

    // R10: disable forces gates off in the same cycle.
    set_cmd(2'b10); cyc(30);
    boff = 1'b1;
    #1;
    check("R10 immediate off", now_gates(), 4'b0000);
    cyc(10);
    check("R10 held off", now_gates(), 4'b0000);

    // R6/R7/R8: sense held high, period phase set by releasing disable.
    sense = 1'b1;
    cyc(5);
    boff = 1'b0;
    cyc(BL / 2);
    check("R6 drive during blanking", now_gates(), 4'b1001);
    cyc(22 - BL / 2);
    check("R7 slow decay after trip", now_gates(), 4'b0101);
    cyc(PER - 3 - 22);
    check("R7 held until boundary", now_gates(), 4'b0101);
    cyc(11);
    check("R8 re-drive after first boundary", now_gates(), 4'b1001);
    cyc(2 * PER - 3 - (PER + 8));
    check("R7 second trip held", now_gates(), 4'b0101);
    cyc(11);
    check("R8 re-drive after second boundary", now_gates(), 4'b1001);
    sense = 1'b0;
    cyc(PER + 5);
    check("R11 sense released follows command", now_gates(), 4'b1001);

    // Random commands; R9 sense noise in coast/brake; R11 clean following.
    for (int it = 0; it < 60; it++) begin
      logic [1:0] ab;
      ab = 2'($urandom % 4);
      set_cmd(ab);
      if (ab == 2'b00 || ab == 2'b11) begin
        held = 1'b1;
        for (int k = 0; k < 40; k++) begin
          sense = 1'($urandom % 2);
          cyc(1);
          if (k >= 25 && now_gates() != gates_for(ab)) begin
            held = 1'b0;
            obs = now_gates();
          end
        end
        sense = 1'b0;
        check("R9 sense ignored in idle state",
              held ? gates_for(ab) : obs, gates_for(ab));
      end else begin
        sense = 1'b0;
        cyc(30);
        check("R11 random command", now_gates(), gates_for(ab));
      end
    end

    checks++;
    if (shoot_viol != 0) begin
      errors++;
      $display("FAIL R5 overlap: actual=%0d expected=0", shoot_viol);
    end
    checks++;
    if (gap_viol != 0) begin
      errors++;
      $display("FAIL R5 dead gap: actual=%0d expected=0", gap_viol);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule